// File: doc/BRIEF.md
# Bus-Attached Timestamp and Interval Timer

This peripheral sits on a simple 32-bit register bus and provides two time sources driven by a 10 MHz tick enable, so one count is worth 100 ns. A 64-bit timestamp counter advances on every tick and can be loaded by software, which lets the time of day be set with 100 ns resolution. A separate 64-bit interval counter counts down toward zero and raises an interrupt when it expires. Software re-arms it after each interrupt by clearing the upper half and writing the reload value into the lower half. For example, a reload of 100,000 gives a 100 Hz system tick and a reload of 10,000,000 gives one second.

The bus address `bus_addr` is a word index, so word N sits at byte offset 4*N. The words are:

| Word | Content |
|------|---------|
| 0 | fixed identification tag |
| 1 | control/status |
| 2 | timestamp upper half |
| 3 | timestamp lower half |
| 4 | interval upper half |
| 5 | interval lower half |

Reads are combinational from `bus_addr` while `bus_re` is high. Their side effects take place at the clock edge that ends the read cycle. A read of the timestamp lower half snapshots the upper half, so the next upper-half read matches it even if a carry happened in between.

The interval counter is governed by a three-state machine:

- **DN_IDLE**: not counting. It moves to DN_RUN when the enable bit is set, the count is nonzero and no interval word is being written that cycle.
- **DN_RUN**: decrements once per tick. It moves to DN_EXPIRED on the tick that takes the count from 1 to 0. It moves to DN_IDLE when enable is cleared or when the count is found at zero because software wrote zero.
- **DN_EXPIRED**: holds at zero. It moves to DN_IDLE on any interval-word write or when enable is cleared.

Top module: `tstamp_timer`

## Requirements
- R1: A read of word 0 always returns the parameter TAG_VALUE, and writes to word 0 change nothing.
- R2: Reset clears both counters, the snapshot register and all control bits, and drives `irq` low.
- R3: The timestamp counter increases by exactly one in each cycle with `tick_en` high and no timestamp write. It holds otherwise, carrying from the lower into the upper half.
- R4: A write to word 2 loads the upper timestamp half and a write to word 3 loads the lower half. The other half is unchanged, and a write overrides a tick in the same cycle.
- R5: A read of word 3 captures the upper timestamp half into a snapshot register. Reads of word 2 return that snapshot, even after a later carry.
- R6: The control word uses bit 0 for enable, bit 1 for interrupt enable and bit 2 for pending. A write sets bits 0 and 1 from the data; writing 0 to bit 2 clears pending, and writing 1 leaves it unchanged.
- R7: Writes to words 4 and 5 load the upper and lower interval halves, and take priority over a decrement. The interval counter decrements only in DN_RUN, with enable set and a tick present.
- R8: The tick that takes the interval count from 1 to 0 sets pending. The counter then stays at zero on further ticks and does not wrap.
- R9: `irq` is high exactly when both pending and interrupt enable are set.
- R10: A read of the control word returns the current pending bit and then clears it, unless an expiry sets it in that same cycle.
- R11: After enable is set with a nonzero count, the first cycle spends in DN_IDLE. A tick in that cycle is not counted; counting starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle 10 MHz time-base strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effects at clock edge) |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted timestamp shows on the next read of word 3 as a value off from the count of ticks delivered. A wrong snapshot shows on the first word-2 read after a carry. A wrong interval-state register shows as a count that either moves while disabled or fails to move in the cycle after arming, and it is visible on the next read of word 5. A pending bit that is set, kept or cleared on the wrong cycle shows on `irq` one cycle after the offending edge, and again on the next control-word read.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    // Register word indices (timestamp halves must stay at words 2 and 3)
    localparam int REG_TAG   = 0;
    localparam int REG_CTRL  = 1;
    localparam int REG_FR_HI = 2;
    localparam int REG_FR_LO = 3;
    localparam int REG_DN_HI = 4;
    localparam int REG_DN_LO = 5;

    // Control word bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_PEND_BIT = 2;
    localparam int CTRL_W        = 3;

    typedef enum logic [1:0] {
        DN_IDLE    = 2'd0,
        DN_RUN     = 2'd1,
        DN_EXPIRED = 2'd2
    } dn_state_e;
endpackage

// File: rtl/tstamp_fr_counter.sv
module tstamp_fr_counter #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic                rd_lo,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] count,
    output logic [WORD_W-1:0]   shadow_hi
);
    localparam int CNT_W = 2 * WORD_W;

    // Load beats increment; each half is loaded on its own
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) count[CNT_W-1:WORD_W] <= wdata;
            if (wr_lo) count[WORD_W-1:0]     <= wdata;
        end else if (tick_en) begin
            count <= count + CNT_W'(1);
        end
    end

    // Snapshot of the upper half, taken when the lower half is read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_hi <= '0;
        end else if (rd_lo) begin
            shadow_hi <= count[CNT_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/tstamp_down_timer.sv
module tstamp_down_timer
    import tstamp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                run_en,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] count,
    output logic                expire
);
    localparam int CNT_W = 2 * WORD_W;

    dn_state_e state_q, state_d;
    logic      dn_wr;
    logic      do_dec;

    assign dn_wr  = wr_hi || wr_lo;
    assign do_dec = (state_q == DN_RUN) && run_en && tick_en && !dn_wr
                    && (count != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DN_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DN_IDLE: begin
                if (run_en && !dn_wr && (count != '0)) state_d = DN_RUN;
            end
            DN_RUN: begin
                if (!run_en)                       state_d = DN_IDLE;
                else if (expire)                   state_d = DN_EXPIRED;
                else if (!dn_wr && count == '0)    state_d = DN_IDLE;
            end
            DN_EXPIRED: begin
                if (!run_en || dn_wr)              state_d = DN_IDLE;
            end
            default:                               state_d = DN_IDLE;
        endcase
    end

    // Outputs: expiry strobe on the 1 -> 0 tick
    always_comb begin
        expire = do_dec && (count == CNT_W'(1));
    end

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (dn_wr) begin
            if (wr_hi) count[CNT_W-1:WORD_W] <= wdata;
            if (wr_lo) count[WORD_W-1:0]     <= wdata;
        end else if (do_dec) begin
            count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tstamp_ctrl_regs.sv
module tstamp_ctrl_regs
    import tstamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              rd_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              expire,
    output logic              en_q,
    output logic              ie_q,
    output logic              pend_q,
    output logic              irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q <= wdata[CTRL_EN_BIT];
            ie_q <= wdata[CTRL_IE_BIT];
        end
    end

    // Expiry wins over both clearing paths
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (expire) begin
            pend_q <= 1'b1;
        end else if (wr_ctrl && !wdata[CTRL_PEND_BIT]) begin
            pend_q <= 1'b0;
        end else if (rd_ctrl) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        irq = pend_q && ie_q;
    end
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer
    import tstamp_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter int          ADDR_W    = 3,
    parameter logic [31:0] TAG_VALUE = 32'h7D3E_0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * WORD_W;

    logic sel_ctrl, sel_fr_hi, sel_fr_lo, sel_dn_hi, sel_dn_lo;
    logic [CNT_W-1:0]  fr_count;
    logic [WORD_W-1:0] fr_shadow;
    logic [CNT_W-1:0]  dn_count;
    logic              dn_expire;
    logic              en_q, ie_q, pend_q;

    assign sel_ctrl  = (bus_addr == ADDR_W'(REG_CTRL));
    assign sel_fr_hi = (bus_addr == ADDR_W'(REG_FR_HI));
    assign sel_fr_lo = (bus_addr == ADDR_W'(REG_FR_LO));
    assign sel_dn_hi = (bus_addr == ADDR_W'(REG_DN_HI));
    assign sel_dn_lo = (bus_addr == ADDR_W'(REG_DN_LO));

    tstamp_fr_counter #(.WORD_W(WORD_W)) u_fr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_hi    (bus_we && sel_fr_hi),
        .wr_lo    (bus_we && sel_fr_lo),
        .rd_lo    (bus_re && sel_fr_lo),
        .wdata    (bus_wdata),
        .count    (fr_count),
        .shadow_hi(fr_shadow)
    );

    tstamp_down_timer #(.WORD_W(WORD_W)) u_dn (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .run_en (en_q),
        .wr_hi  (bus_we && sel_dn_hi),
        .wr_lo  (bus_we && sel_dn_lo),
        .wdata  (bus_wdata),
        .count  (dn_count),
        .expire (dn_expire)
    );

    tstamp_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(bus_we && sel_ctrl),
        .rd_ctrl(bus_re && sel_ctrl),
        .wdata  (bus_wdata[CTRL_W-1:0]),
        .expire (dn_expire),
        .en_q   (en_q),
        .ie_q   (ie_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_TAG):   bus_rdata = WORD_W'(TAG_VALUE);
            ADDR_W'(REG_CTRL): begin
                bus_rdata[CTRL_EN_BIT]   = en_q;
                bus_rdata[CTRL_IE_BIT]   = ie_q;
                bus_rdata[CTRL_PEND_BIT] = pend_q;
            end
            ADDR_W'(REG_FR_HI): bus_rdata = fr_shadow;
            ADDR_W'(REG_FR_LO): bus_rdata = fr_count[WORD_W-1:0];
            ADDR_W'(REG_DN_HI): bus_rdata = dn_count[CNT_W-1:WORD_W];
            ADDR_W'(REG_DN_LO): bus_rdata = dn_count[WORD_W-1:0];
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tstamp_timer_chk.sv
module tstamp_timer_chk #(
    parameter int          WORD_W    = 32,
    parameter int          ADDR_W    = 3,
    parameter logic [31:0] TAG_VALUE = 32'h7D3E_0A11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic                bus_re,
    input logic [WORD_W-1:0]   bus_rdata,
    input logic                irq,
    input logic [2*WORD_W-1:0] fr_count,
    input logic [2*WORD_W-1:0] dn_count,
    input logic                dn_expire,
    input logic                pend_q,
    input logic                ie_q
);
    localparam int CNT_W = 2 * WORD_W;

    logic fr_wr, dn_wr, ctrl_rd;
    assign fr_wr   = bus_we && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3));
    assign dn_wr   = bus_we && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(5));
    assign ctrl_rd = bus_re && (bus_addr == ADDR_W'(1));

    assert_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(0)) |-> bus_rdata == WORD_W'(TAG_VALUE));

    assert_fr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick_en) && !$past(fr_wr))
            |-> fr_count == $past(fr_count) + CNT_W'(1));

    assert_fr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick_en) && !$past(fr_wr))
            |-> fr_count == $past(fr_count));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dn_count) == '0 && !$past(dn_wr))
            |-> dn_count == '0);

    assert_pend_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pend_q) && pend_q) |-> $past(dn_expire));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q && ie_q));

    assert_rd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctrl_rd) && !$past(dn_expire)) |-> !pend_q);
endmodule

bind tstamp_timer tstamp_timer_chk #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .TAG_VALUE(TAG_VALUE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .fr_count (fr_count),
    .dn_count (dn_count),
    .dn_expire(dn_expire),
    .pend_q   (pend_q),
    .ie_q     (ie_q)
);

// File: tb/tstamp_timer_bench.sv
`timescale 1ns/1ps
module tstamp_timer_bench;
    localparam logic [31:0] TAG = 32'h7D3E_0A11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] smp_rd;
    logic        smp_irq;

    always #10 clk = ~clk;

    tstamp_timer u_tstamp_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic        re;
        logic [2:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    // Word map: 0 tag, 1 ctrl, 2 fr hi, 3 fr lo, 4 dn hi, 5 dn lo
    localparam step_t STEPS [14] = '{
        '{1'b0, 1'b1, 3'd0, 32'h0,        TAG,          4'd1},  // R1 tag
        '{1'b1, 1'b0, 3'd0, 32'hFFFF_FFFF, 32'h0,       4'd1},  // R1 write ignored
        '{1'b0, 1'b1, 3'd0, 32'h0,        TAG,          4'd1},  // R1 tag again
        '{1'b1, 1'b0, 3'd2, 32'h12,       32'h0,        4'd4},  // R4 load hi
        '{1'b1, 1'b0, 3'd3, 32'hFFFF_FFFE, 32'h0,       4'd4},  // R4 load lo
        '{1'b0, 1'b1, 3'd3, 32'h0,        32'hFFFF_FFFE, 4'd4}, // R4 read lo
        '{1'b0, 1'b1, 3'd2, 32'h0,        32'h12,       4'd5},  // R5 snapshot hi
        '{1'b1, 1'b0, 3'd4, 32'h0,        32'h0,        4'd7},  // R7 dn hi
        '{1'b1, 1'b0, 3'd5, 32'd5,        32'h0,        4'd7},  // R7 dn lo
        '{1'b0, 1'b1, 3'd5, 32'h0,        32'd5,        4'd7},  // R7 read lo
        '{1'b0, 1'b1, 3'd4, 32'h0,        32'h0,        4'd7},  // R7 read hi
        '{1'b0, 1'b1, 3'd1, 32'h0,        32'h0,        4'd6},  // R6 ctrl idle
        '{1'b1, 1'b0, 3'd1, 32'h3,        32'h0,        4'd6},  // R6 en+ie
        '{1'b0, 1'b1, 3'd1, 32'h0,        32'h3,        4'd6}   // R6 readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic re, input logic [2:0] a,
                      input logic [31:0] wd, input logic tk);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; tick_en = tk;
        #1;
        smp_rd  = bus_rdata;
        smp_irq = irq;
        @(posedge clk);
    endtask

    task automatic idle(input logic tk);
        op(1'b0, 1'b0, 3'd0, 32'h0, tk);
    endtask

    task automatic rd(input logic [2:0] a);
        op(1'b0, 1'b1, a, 32'h0, 1'b0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] wd);
        op(1'b1, 1'b0, a, wd, 1'b0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state
        rd(3'd1); check("R2 ctrl", smp_rd, 32'h0);
        check("R2 irq", {31'b0, smp_irq}, 32'h0);
        rd(3'd3); check("R2 fr lo", smp_rd, 32'h0);
        rd(3'd2); check("R2 fr hi", smp_rd, 32'h0);
        rd(3'd5); check("R2 dn lo", smp_rd, 32'h0);

        for (int i = 0; i < 14; i++) begin
            op(STEPS[i].we, STEPS[i].re, STEPS[i].addr, STEPS[i].wd, 1'b0);
            if (STEPS[i].re) begin
                checks++;
                if (smp_rd !== STEPS[i].exp) begin
                    errors++;
                    $display("FAIL table step %0d R%0d: actual %h expected %h",
                             i, STEPS[i].req, smp_rd, STEPS[i].exp);
                end
            end
        end

        // fr = 0x12_FFFFFFFE, dn = 5, DN_RUN
        idle(1'b1);                                  // fr ..FFFF, dn 4
        rd(3'd3); check("R3 fr lo tick", smp_rd, 32'hFFFF_FFFF);
        idle(1'b1);                                  // carry, dn 3
        rd(3'd2); check("R5 stale snapshot", smp_rd, 32'h12);
        rd(3'd3); check("R3 carry lo", smp_rd, 32'h0);
        rd(3'd2); check("R3 carry hi", smp_rd, 32'h13);

        idle(1'b1); idle(1'b1);                      // dn 1
        idle(1'b0); check("R9 no irq yet", {31'b0, smp_irq}, 32'h0);
        idle(1'b1);                                  // dn 0, pending
        rd(3'd5); check("R8 zero", smp_rd, 32'h0);
        check("R9 irq up", {31'b0, smp_irq}, 32'h1);
        idle(1'b1); idle(1'b1);
        rd(3'd5); check("R8 no wrap", smp_rd, 32'h0);
        check("R8 irq held", {31'b0, smp_irq}, 32'h1);

        wr(3'd1, 32'h5);                             // en, ie off, keep pend
        rd(3'd1); check("R6 pend kept", smp_rd, 32'h5);
        check("R9 masked", {31'b0, smp_irq}, 32'h0);
        rd(3'd1); check("R10 read clears", smp_rd, 32'h1);

        wr(3'd4, 32'h0);
        wr(3'd5, 32'd2);
        wr(3'd1, 32'h3);                             // -> DN_RUN
        idle(1'b1); idle(1'b1);                      // expire
        idle(1'b0); check("R9 irq rearm", {31'b0, smp_irq}, 32'h1);
        wr(3'd1, 32'h3);                             // bit2 = 0 clears
        idle(1'b0); check("R6 write clear", {31'b0, smp_irq}, 32'h0);
        rd(3'd1); check("R6 ctrl after clear", smp_rd, 32'h3);

        wr(3'd1, 32'h0);
        wr(3'd5, 32'd7);
        idle(1'b1); idle(1'b1); idle(1'b1);
        rd(3'd5); check("R7 disabled hold", smp_rd, 32'd7);

        wr(3'd1, 32'h1);
        idle(1'b1);                                  // DN_IDLE cycle
        rd(3'd5); check("R11 first tick skipped", smp_rd, 32'd7);
        idle(1'b1);
        rd(3'd5); check("R11 counting", smp_rd, 32'd6);

        wr(3'd2, 32'h0);
        op(1'b1, 1'b0, 3'd3, 32'd100, 1'b1);         // write beats tick
        rd(3'd3); check("R4 write priority", smp_rd, 32'd100);
        idle(1'b1); idle(1'b1); idle(1'b1);
        rd(3'd3); check("R3 three ticks", smp_rd, 32'd103);
        idle(1'b0);
        rd(3'd3); check("R3 hold", smp_rd, 32'd103);

        // R2 reset while running
        @(negedge clk) rst_n = 1'b0;
        idle(1'b0);
        @(negedge clk) rst_n = 1'b1;
        rd(3'd1); check("R2 ctrl after reset", smp_rd, 32'h0);
        rd(3'd5); check("R2 dn after reset", smp_rd, 32'h0);
        rd(3'd3); check("R2 fr after reset", smp_rd, 32'h0);

        finish_run();
    end
endmodule